// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of the write state machine of a parallel flash controller model. It watches a stream of qualified bus write strobes, each carrying a 15-bit command address and an 8-bit command byte. A command is only recognised after a two-write unlock prefix. The decoder then updates the read-path selector, which chooses between the memory array, the two identifier bytes and the status register. It also issues single-cycle start requests for page programming and whole-chip erase, and a single-cycle request to clear the failure flags of the status register.

While the write state machine reports busy, the decoder accepts only the read-status command. It drops every other command without effect. A write that does not match the next expected step of a sequence sends the tracker back to its start and leaves the read selector alone. Only writes made while the programming-voltage qualifier is high and output enable is inactive are seen at all.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, rd_mode is 2'd0 (array), id_data is 8'h00, and pgm_start, erase_start and clr_status are low.
- R2: A write is used only in a cycle where wr_stb=1, hv_wr_en=1 and oe_n=1. Any other strobe is ignored entirely: it does not advance the sequence, break it, or end identifier mode.
- R3: A command sequence starts with 8'hAA at address 15'h5555, followed by 8'h55 at 15'h2AAA. The command byte comes next, at 15'h5555. If either unlock write is wrong, the command byte that follows has no effect.
- R4: These command bytes set rd_mode on the clock edge that samples the write: 8'hF0 selects 2'd0 (array), 8'h90 selects 2'd1 (identifier) and 8'h70 selects 2'd2 (status).
- R5: Command byte 8'hA0 raises pgm_start for exactly one cycle after the sampling edge and sets rd_mode to 2'd2.
- R6: Chip erase uses six writes: the unlock pair, 8'h80 at 15'h5555, the unlock pair again, then 8'h10 at 15'h5555. erase_start pulses for one cycle only after the sixth write, and rd_mode becomes 2'd2.
- R7: Command byte 8'h50 raises clr_status for exactly one cycle and leaves rd_mode unchanged.
- R8: In identifier mode, id_data is 8'hC2 when rd_lsb=0 and 8'h6B when rd_lsb=1. In every other mode id_data is 8'h00. The next qualified write of any kind returns rd_mode to 2'd0.
- R9: While wsm_busy=1, only command byte 8'h70 takes effect. The bytes F0, 90, A0, 50 and 80 change neither rd_mode nor any pulse output.
- R10: A qualified write that breaks an expected step returns the tracker to its start without changing rd_mode. A later complete sequence is then decoded normally.
- R11: pgm_start and erase_start never rise unless wsm_busy was low on the sampling edge. An erase whose sixth write arrives while busy is dropped.
- R12: After a program or erase start, rd_mode stays at 2'd2 through the busy period and after it ends, until a new valid command changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 15 | Low address bits of the write |
| wr_data | input | 8 | Low data byte of the write (command code) |
| oe_n | input | 1 | Output enable, active low; writes need it high |
| hv_wr_en | input | 1 | Programming-voltage write qualifier, active high |
| wsm_busy | input | 1 | Write state machine busy |
| rd_lsb | input | 1 | Read offset bit for the identifier bytes |
| rd_mode | output | 2 | Read-path select: 0 array, 1 identifier, 2 status |
| id_data | output | 8 | Identifier byte for the current offset |
| pgm_start | output | 1 | One-cycle page-program start request |
| erase_start | output | 1 | One-cycle chip-erase start request |
| clr_status | output | 1 | One-cycle clear-status request |

## Verification
Most faults in the sequence tracker only show up on the write after the one that caused them. A tracker left mid-sequence, or one that failed to reset on a mismatch, appears when the next command byte changes rd_mode or a start pulse when it should not, or fails to when it should. A wrong read-mode register shows on rd_mode and id_data on the first edge after the offending write. A missing busy filter shows as a start pulse or a mode change during busy, within one cycle of the final command write. The directed scenarios therefore follow each disturbing write with a complete command and check the ports on the very next cycle.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int CMD_ADDR_W = 15;
  localparam int CMD_DATA_W = 8;

  localparam logic [CMD_ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [CMD_DATA_W-1:0] KEY_BYTE_A = 8'hAA;
  localparam logic [CMD_DATA_W-1:0] KEY_BYTE_B = 8'h55;
  localparam logic [CMD_DATA_W-1:0] OP_ARRAY   = 8'hF0;
  localparam logic [CMD_DATA_W-1:0] OP_IDENT   = 8'h90;
  localparam logic [CMD_DATA_W-1:0] OP_PROG    = 8'hA0;
  localparam logic [CMD_DATA_W-1:0] OP_STATUS  = 8'h70;
  localparam logic [CMD_DATA_W-1:0] OP_CLEAR   = 8'h50;
  localparam logic [CMD_DATA_W-1:0] OP_ERSETUP = 8'h80;
  localparam logic [CMD_DATA_W-1:0] OP_ERGO    = 8'h10;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ARRAY,
    CMD_IDENT,
    CMD_PROG,
    CMD_STATUS,
    CMD_CLEAR,
    CMD_ERASE
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_ER0,
    SQ_ER1,
    SQ_ER2
  } seq_st_e;

endpackage

// File: rtl/fcmd_wqual.sv
module fcmd_wqual (
  input  logic wr_stb,
  input  logic oe_n,
  input  logic hv_wr_en,
  output logic wr_vld
);

  // a write counts only with the voltage qualifier up and outputs off
  always_comb begin
    wr_vld = wr_stb & hv_wr_en & oe_n;
  end

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_vld,
  input  logic [CMD_ADDR_W-1:0] addr,
  input  logic [CMD_DATA_W-1:0] data,
  input  logic                  busy,
  output cmd_e                  cmd
);

  seq_st_e st_q, st_d;
  logic    at_a, at_b, key_a, key_b;

  always_comb begin
    at_a  = (addr == KEY_ADDR_A);
    at_b  = (addr == KEY_ADDR_B);
    key_a = at_a && (data == KEY_BYTE_A);
    key_b = at_b && (data == KEY_BYTE_B);
  end

  // next-state and command decode
  always_comb begin
    st_d = st_q;
    cmd  = CMD_NONE;
    if (wr_vld) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (key_a) st_d = SQ_KEY1;
        SQ_KEY1: if (key_b) st_d = SQ_KEY2;
        SQ_KEY2: begin
          if (at_a) begin
            if (data == OP_STATUS) cmd = CMD_STATUS;
            else if (!busy) begin
              if      (data == OP_ARRAY)   cmd  = CMD_ARRAY;
              else if (data == OP_IDENT)   cmd  = CMD_IDENT;
              else if (data == OP_PROG)    cmd  = CMD_PROG;
              else if (data == OP_CLEAR)   cmd  = CMD_CLEAR;
              else if (data == OP_ERSETUP) st_d = SQ_ER0;
            end
          end
        end
        SQ_ER0: if (key_a) st_d = SQ_ER1;
        SQ_ER1: if (key_b) st_d = SQ_ER2;
        SQ_ER2: if (at_a && data == OP_ERGO && !busy) cmd = CMD_ERASE;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= SQ_IDLE;
    else if (wr_vld) st_q <= st_d;
  end

  // R9: while busy the decoder emits nothing but the status command
  a_r9_busy_status_only: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cmd == CMD_NONE || cmd == CMD_STATUS));

  // R2: the tracker holds when no qualified write arrives
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(st_q));

endmodule

// File: rtl/fcmd_mode.sv
module fcmd_mode
  import fcmd_pkg::*;
#(
  parameter logic [CMD_DATA_W-1:0] MFR_CODE = 8'hC2,
  parameter logic [CMD_DATA_W-1:0] DEV_CODE = 8'h6B
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_vld,
  input  cmd_e                  cmd,
  input  logic                  rd_lsb,
  output rd_mode_e              mode,
  output logic [CMD_DATA_W-1:0] id_byte,
  output logic                  pgm_pulse,
  output logic                  ers_pulse,
  output logic                  clr_pulse
);

  rd_mode_e mode_q, mode_d;
  logic     pgm_d, ers_d, clr_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_q == RM_IDENT) mode_d = RM_ARRAY;  // any write ends identifier reads
    unique case (cmd)
      CMD_ARRAY:                     mode_d = RM_ARRAY;
      CMD_IDENT:                     mode_d = RM_IDENT;
      CMD_STATUS, CMD_PROG, CMD_ERASE: mode_d = RM_STATUS;
      default: ;
    endcase
    pgm_d = (cmd == CMD_PROG);
    ers_d = (cmd == CMD_ERASE);
    clr_d = (cmd == CMD_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= RM_ARRAY;
    else if (wr_vld) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_pulse <= 1'b0;
      ers_pulse <= 1'b0;
      clr_pulse <= 1'b0;
    end else begin
      pgm_pulse <= pgm_d;
      ers_pulse <= ers_d;
      clr_pulse <= clr_d;
    end
  end

  always_comb begin
    mode    = mode_q;
    id_byte = '0;
    if (mode_q == RM_IDENT) id_byte = rd_lsb ? DEV_CODE : MFR_CODE;
  end

  // R5 / R6 / R7: each request lasts a single cycle
  a_r5_pgm_single: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |=> !pgm_pulse);
  a_r6_ers_single: assert property (@(posedge clk) disable iff (!rst_n)
    ers_pulse |=> !ers_pulse);
  a_r7_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_pulse, ers_pulse, clr_pulse}));
  // R5 / R6: a start request leaves the read path on status
  a_r5_start_status: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_pulse || ers_pulse) |-> mode_q == RM_STATUS);
  // R7: clearing status does not move the read path
  a_r7_clear_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> mode_q == $past(mode_q));

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'h6B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [14:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        oe_n,
  input  logic        hv_wr_en,
  input  logic        wsm_busy,
  input  logic        rd_lsb,
  output logic [1:0]  rd_mode,
  output logic [7:0]  id_data,
  output logic        pgm_start,
  output logic        erase_start,
  output logic        clr_status
);

  logic     wr_vld;
  cmd_e     cmd;
  rd_mode_e mode;

  fcmd_wqual u_wqual (
    .wr_stb   (wr_stb),
    .oe_n     (oe_n),
    .hv_wr_en (hv_wr_en),
    .wr_vld   (wr_vld)
  );

  fcmd_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_vld (wr_vld),
    .addr   (wr_addr),
    .data   (wr_data),
    .busy   (wsm_busy),
    .cmd    (cmd)
  );

  fcmd_mode #(
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_vld    (wr_vld),
    .cmd       (cmd),
    .rd_lsb    (rd_lsb),
    .mode      (mode),
    .id_byte   (id_data),
    .pgm_pulse (pgm_start),
    .ers_pulse (erase_start),
    .clr_pulse (clr_status)
  );

  assign rd_mode = mode;

  // R2: without a qualified write the read path never moves
  a_r2_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && hv_wr_en && oe_n) |=> $stable(rd_mode));
  // R11: start requests only follow an idle write machine
  a_r11_pgm_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !$past(wsm_busy));
  a_r11_ers_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(wsm_busy));
  // R8: identifier bytes only while identifier mode is selected
  a_r8_id_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != 2'd1) |-> id_data == 8'h00);

endmodule

// File: tb/fcmd_decoder_tb.sv
`timescale 1ns/100ps
module fcmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        oe_n = 1'b1;
  logic        hv_wr_en = 1'b1;
  logic        wsm_busy = 1'b0;
  logic        rd_lsb = 1'b0;
  logic [1:0]  rd_mode;
  logic [7:0]  id_data;
  logic        pgm_start, erase_start, clr_status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  fcmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .oe_n(oe_n), .hv_wr_en(hv_wr_en),
    .wsm_busy(wsm_busy), .rd_lsb(rd_lsb), .rd_mode(rd_mode),
    .id_data(id_data), .pgm_start(pgm_start), .erase_start(erase_start),
    .clr_status(clr_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one write cycle; returns at the falling edge after the sampling edge
  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] op);
    wr(15'h5555, 8'hAA);
    wr(15'h2AAA, 8'h55);
    wr(15'h5555, op);
  endtask

  task automatic idle1();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd_mode", rd_mode, 0);
    chk("R1 id_data", id_data, 0);
    chk("R1 pulses", {pgm_start, erase_start, clr_status}, 0);
  endtask

  task automatic t_modes();
    cmd3(8'h90);
    chk("R4 ident mode", rd_mode, 1);
    rd_lsb = 1'b0; #1;
    chk("R8 mfr byte", id_data, 8'hC2);
    rd_lsb = 1'b1; #1;
    chk("R8 dev byte", id_data, 8'h6B);
    wr(15'h1234, 8'h00);
    chk("R8 write ends ident", rd_mode, 0);
    chk("R8 id quiet", id_data, 0);
    cmd3(8'h70);
    chk("R4 status mode", rd_mode, 2);
    cmd3(8'hF0);
    chk("R4 array mode", rd_mode, 0);
  endtask

  task automatic t_qual();
    hv_wr_en = 1'b0;
    cmd3(8'h70);
    chk("R2 no hv", rd_mode, 0);
    hv_wr_en = 1'b1; oe_n = 1'b0;
    cmd3(8'h70);
    chk("R2 oe active", rd_mode, 0);
    oe_n = 1'b1;
    // an unqualified junk write in mid-sequence must not break it
    wr(15'h5555, 8'hAA);
    hv_wr_en = 1'b0; wr(15'h0001, 8'h33); hv_wr_en = 1'b1;
    wr(15'h2AAA, 8'h55);
    wr(15'h5555, 8'h70);
    chk("R2 junk ignored", rd_mode, 2);
    cmd3(8'hF0);
  endtask

  task automatic t_unlock();
    wr(15'h5554, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h70);
    chk("R3 bad first addr", rd_mode, 0);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h54); wr(15'h5555, 8'h70);
    chk("R3 bad second data", rd_mode, 0);
    cmd3(8'h70);
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h33);
    chk("R10 bad op keeps mode", rd_mode, 2);
    wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hF0);
    chk("R10 break keeps mode", rd_mode, 2);
    cmd3(8'hF0);
    chk("R10 recovers", rd_mode, 0);
  endtask

  task automatic t_program();
    cmd3(8'hA0);
    chk("R5 pgm pulse", pgm_start, 1);
    chk("R5 status mode", rd_mode, 2);
    idle1();
    chk("R5 pgm single", pgm_start, 0);
    cmd3(8'hF0);
  endtask

  task automatic t_clear();
    cmd3(8'h50);
    chk("R7 clr pulse", clr_status, 1);
    chk("R7 mode kept", rd_mode, 0);
    idle1();
    chk("R7 clr single", clr_status, 0);
  endtask

  task automatic t_erase();
    cmd3(8'h80);
    wr(15'h5555, 8'hAA);
    wr(15'h2AAA, 8'h55);
    chk("R6 no early erase", erase_start, 0);
    wr(15'h5555, 8'h10);
    chk("R6 erase pulse", erase_start, 1);
    chk("R6 status mode", rd_mode, 2);
    idle1();
    chk("R6 erase single", erase_start, 0);
  endtask

  task automatic t_busy();
    cmd3(8'hF0);
    wsm_busy = 1'b1;
    cmd3(8'h90);
    chk("R9 ident blocked", rd_mode, 0);
    cmd3(8'h50);
    chk("R9 clear blocked", clr_status, 0);
    cmd3(8'hA0);
    chk("R9 program blocked", pgm_start, 0);
    cmd3(8'h70);
    chk("R9 status accepted", rd_mode, 2);
    cmd3(8'hF0);
    chk("R9 reset blocked", rd_mode, 2);
    wsm_busy = 1'b0;
    cmd3(8'h80); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
    wsm_busy = 1'b1;
    wr(15'h5555, 8'h10);
    chk("R11 erase dropped", erase_start, 0);
    wsm_busy = 1'b0;
    cmd3(8'hF0);
    cmd3(8'hA0);
    wsm_busy = 1'b1;
    repeat (3) idle1();
    chk("R12 status while busy", rd_mode, 2);
    wsm_busy = 1'b0;
    repeat (3) idle1();
    chk("R12 status after busy", rd_mode, 2);
    cmd3(8'hF0);
    chk("R12 new command", rd_mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_qual();
    t_unlock();
    t_program();
    t_clear();
    t_erase();
    t_busy();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule